// File: doc/BRIEF.md
# Serial Channel Clock Generator

This block derives every clock of a synchronous serial channel from one fast system clock. Each derived frequency is carried as a single-cycle enable pulse in the system clock domain, so nothing downstream needs a second clock domain. A source selector picks the input rate: a pulse stream from an external fractional divider, the rising edges of a trigger input, or the rising edges of an external clock. The trigger and external clock inputs are asynchronous and pass through a synchronizer first. An optional halving stage follows. A programmable integer divider then produces the divided rate, and the shift clock toggles on each divided pulse.

A second path counts time quanta. A four-way selector feeds it from one of four streams: the divided rate, the post-halving rate, shift clock rising edges or master clock rising edges. Two cascaded counters then divide that stream. The master clock and shift clock pins have programmable idle levels. The shift clock pin can also be delayed by half a shift clock period, or driven from the synchronized external clock instead. While the generator is disabled, all internal state is held clear and both pins rest at their idle levels.

Top module: `ser_clkgen`

## Requirements
- R1: With `src_sel` equal to 0 or 1 (1 behaves as 0), each cycle where `frac_en_i` is high is one input-rate pulse.
- R2: With `src_sel` = 2, each rising edge of `trig_i`, seen after a two-flop synchronizer, is one input-rate pulse, and the internal master clock toggles on each such pulse.
- R3: With `src_sel` = 3, each synchronized rising edge of `ext_clk_i` is one input-rate pulse, and while halving is off the master clock equals the synchronized `ext_clk_i` level.
- R4: With `half_en` = 0, `ppp_en_o` equals the input-rate pulse. With `half_en` = 1, `ppp_en_o` fires on every second input-rate pulse, starting with the second after enable, and the master clock toggles on every input-rate pulse, giving half the input rate.
- R5: `pdiv_en_o` fires on every (`pdiv` + 1)-th `ppp_en_o` pulse after enable, and only in a cycle where `ppp_en_o` is high.
- R6: The internal shift clock is 0 after enable and toggles on the edge after each `pdiv_en_o` pulse.
- R7: `tq_sel` selects the time-quanta input: 0 is `pdiv_en_o`, 1 is `ppp_en_o`, 2 is shift clock rising edges and 3 is master clock rising edges. Edges of the two clocks are seen one cycle after the change.
- R8: `tq_en_o` fires once every (`tq_pre` + 1) × (`tq_den` + 1) selected input pulses, and only together with one.
- R9: `sclkout_cfg` bit 0 is the shift clock idle level and inverts the pin. With bit 1 set, the pin carries the shift clock value from before the most recent `pdiv_en_o` pulse, which is a half-period delay.
- R10: `mclk_o` is the master clock XOR `mclk_idle`.
- R11: With `sclkout_sel` = 1 and the generator enabled, `sclkout_o` equals the synchronized `ext_clk_i` level.
- R12: While `gen_en` is 0, `mclk_o` = `mclk_idle`, `sclkout_o` = `sclkout_cfg` bit 0, and no enable pulse is output. All divider, halving and clock state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator enable; 0 clears state and idles the pins |
| frac_en_i | input | 1 | Fractional-divider enable pulse |
| trig_i | input | 1 | Asynchronous trigger input |
| ext_clk_i | input | 1 | Asynchronous external clock input |
| src_sel | input | 2 | Input-rate source select |
| half_en | input | 1 | 2:1 stage enable |
| pdiv | input | PDIV_W | Integer divider factor (divide by value + 1) |
| tq_sel | input | 2 | Time-quanta input select |
| tq_pre | input | PRE_W | Time-quanta pre-divider (value + 1) |
| tq_den | input | DEN_W | Time-quanta denominator (value + 1) |
| sclkout_cfg | input | 2 | Bit 0 idle level, bit 1 half-period delay |
| mclk_idle | input | 1 | Master clock idle level |
| sclkout_sel | input | 1 | Shift clock pin source: 0 internal, 1 external |
| mclk_o | output | 1 | Master clock pin |
| sclkout_o | output | 1 | Shift clock pin |
| ppp_en_o | output | 1 | Post-halving rate pulse |
| pdiv_en_o | output | 1 | Divided rate pulse |
| tq_en_o | output | 1 | Time-quantum pulse |

## Verification
The bench targets a divider factor of zero, where every post-halving pulse must also be a divided pulse. A design with an off-by-one terminal count would skip pulses here, or would give the shift clock a period that is wrong by one pulse. It checks that code 1 of the source select behaves as code 0, and that halving starts on the second input pulse. An inverted halving phase would shift every divided pulse by one input pulse. The delayed shift clock and the master clock edge feeding the time-quanta path are compared cycle by cycle, so a delay of a full period, or an edge taken from the wrong phase, shows up as a mismatch on the pin or on `tq_en_o`. Repeated enable and disable cycles with new settings check that the pins idle at once and that no state leaks from one run into the next.

// File: rtl/ser_clkgen_pkg.sv
package ser_clkgen_pkg;

   typedef enum logic [1:0] {
      SRC_FRAC = 2'd0,
      SRC_RSVD = 2'd1,
      SRC_TRIG = 2'd2,
      SRC_EXT  = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      TQ_PDIV = 2'd0,
      TQ_PPP  = 2'd1,
      TQ_SCLK = 2'd2,
      TQ_MCLK = 2'd3
   } tq_src_e;

   localparam int unsigned N_EXT_IN = 2;
   localparam int unsigned IDX_TRIG = 0;
   localparam int unsigned IDX_EXT  = 1;

endpackage

// File: rtl/ser_clkgen_sync.sv
module ser_clkgen_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/ser_clkgen_div.sv
module ser_clkgen_div #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         pulse
);

   logic [W-1:0] cnt_q;
   logic         at_limit;

   assign at_limit = (cnt_q == limit);
   assign pulse    = tick & at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/ser_clkgen.sv
module ser_clkgen
   import ser_clkgen_pkg::*;
#(
   parameter int unsigned PDIV_W      = 10,
   parameter int unsigned PRE_W       = 2,
   parameter int unsigned DEN_W       = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen_en,
   input  logic              frac_en_i,
   input  logic              trig_i,
   input  logic              ext_clk_i,
   input  logic [1:0]        src_sel,
   input  logic              half_en,
   input  logic [PDIV_W-1:0] pdiv,
   input  logic [1:0]        tq_sel,
   input  logic [PRE_W-1:0]  tq_pre,
   input  logic [DEN_W-1:0]  tq_den,
   input  logic [1:0]        sclkout_cfg,
   input  logic              mclk_idle,
   input  logic              sclkout_sel,
   output logic              mclk_o,
   output logic              sclkout_o,
   output logic              ppp_en_o,
   output logic              pdiv_en_o,
   output logic              tq_en_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ser_clkgen: SYNC_STAGES must be at least 2");
   end
   if (PDIV_W < 1 || PRE_W < 1 || DEN_W < 1) begin : g_bad_width
      $error("ser_clkgen: divider widths must be at least 1");
   end

   localparam int unsigned N_IN = N_EXT_IN;

   // input synchronizers, one per asynchronous pin
   logic [N_IN-1:0] in_raw, in_lvl, in_rise;
   assign in_raw[IDX_TRIG] = trig_i;
   assign in_raw[IDX_EXT]  = ext_clk_i;

   for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
      ser_clkgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (in_raw[gi]),
         .level_o (in_lvl[gi]),
         .rise_o  (in_rise[gi])
      );
   end

   // input rate selection
   logic pin_sel, pin_en;
   always_comb begin
      unique case (src_e'(src_sel))
         SRC_TRIG: pin_sel = in_rise[IDX_TRIG];
         SRC_EXT:  pin_sel = in_rise[IDX_EXT];
         default:  pin_sel = frac_en_i;
      endcase
   end
   assign pin_en = gen_en & pin_sel;

   // 2:1 stage; its phase flop doubles as the toggling master clock
   logic half_ph_q, ppp_en;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half_ph_q <= 1'b0;
      else if (!gen_en) half_ph_q <= 1'b0;
      else if (pin_en)  half_ph_q <= ~half_ph_q;
   end
   assign ppp_en = half_en ? (pin_en & half_ph_q) : pin_en;

   logic mclk_raw;
   assign mclk_raw = (!half_en && src_e'(src_sel) == SRC_EXT) ? in_lvl[IDX_EXT]
                                                             : half_ph_q;

   // integer divider
   logic pdiv_en;
   ser_clkgen_div #(.W(PDIV_W)) u_pdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~gen_en),
      .tick  (ppp_en),
      .limit (pdiv),
      .pulse (pdiv_en)
   );

   // shift clock, its half-period delayed copy, and edge history
   logic sclk_q, sclk_dly_q, sclk_hist_q, mclk_hist_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q      <= 1'b0;
         sclk_dly_q  <= 1'b0;
         sclk_hist_q <= 1'b0;
         mclk_hist_q <= 1'b0;
      end else if (!gen_en) begin
         sclk_q      <= 1'b0;
         sclk_dly_q  <= 1'b0;
         sclk_hist_q <= 1'b0;
         mclk_hist_q <= 1'b0;
      end else begin
         if (pdiv_en) begin
            sclk_q     <= ~sclk_q;
            sclk_dly_q <= sclk_q;
         end
         sclk_hist_q <= sclk_q;
         mclk_hist_q <= mclk_raw;
      end
   end

   // time quanta path
   logic tq_in, tq_pre_en, tq_en;
   always_comb begin
      unique case (tq_src_e'(tq_sel))
         TQ_PDIV: tq_in = pdiv_en;
         TQ_PPP:  tq_in = ppp_en;
         TQ_SCLK: tq_in = sclk_q & ~sclk_hist_q;
         default: tq_in = mclk_raw & ~mclk_hist_q;
      endcase
   end

   ser_clkgen_div #(.W(PRE_W)) u_tq_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~gen_en),
      .tick  (tq_in & gen_en),
      .limit (tq_pre),
      .pulse (tq_pre_en)
   );

   ser_clkgen_div #(.W(DEN_W)) u_tq_den (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~gen_en),
      .tick  (tq_pre_en),
      .limit (tq_den),
      .pulse (tq_en)
   );

   // pin shaping
   logic sclk_shaped;
   assign sclk_shaped = (sclkout_cfg[1] ? sclk_dly_q : sclk_q) ^ sclkout_cfg[0];

   assign mclk_o    = gen_en ? (mclk_raw ^ mclk_idle) : mclk_idle;
   assign sclkout_o = !gen_en    ? sclkout_cfg[0]
                    : sclkout_sel ? in_lvl[IDX_EXT]
                    : sclk_shaped;
   assign ppp_en_o  = ppp_en;
   assign pdiv_en_o = pdiv_en;
   assign tq_en_o   = tq_en;

endmodule

// File: rtl/ser_clkgen_chk.sv
module ser_clkgen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gen_en,
   input logic       pin_en,
   input logic       ppp_en,
   input logic       pdiv_en,
   input logic       tq_in,
   input logic       tq_en,
   input logic       sclk,
   input logic       mclk_o,
   input logic       sclkout_o,
   input logic       mclk_idle,
   input logic [1:0] sclkout_cfg
);

   a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |-> (mclk_o == mclk_idle) && (sclkout_o == sclkout_cfg[0])
                  && !ppp_en && !pdiv_en && !tq_en);

   a_r4_ppp_from_pin: assert property (@(posedge clk) disable iff (!rst_n)
      ppp_en |-> pin_en);

   a_r5_pdiv_needs_ppp: assert property (@(posedge clk) disable iff (!rst_n)
      pdiv_en |-> ppp_en);

   a_r6_sclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && pdiv_en) |=> (sclk != $past(sclk)));

   a_r6_sclk_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_en && !pdiv_en) |=> $stable(sclk));

   a_r8_tq_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      tq_en |-> tq_in);

endmodule

bind ser_clkgen ser_clkgen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gen_en      (gen_en),
   .pin_en      (pin_en),
   .ppp_en      (ppp_en),
   .pdiv_en     (pdiv_en),
   .tq_in       (tq_in),
   .tq_en       (tq_en),
   .sclk        (sclk_q),
   .mclk_o      (mclk_o),
   .sclkout_o   (sclkout_o),
   .mclk_idle   (mclk_idle),
   .sclkout_cfg (sclkout_cfg)
);

// File: tb/ser_clkgen_test.sv
`timescale 1ns/1ps
module ser_clkgen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gen_en = 1'b0, frac_en_i = 1'b0, trig_i = 1'b0, ext_clk_i = 1'b0;
   logic [1:0] src_sel = '0, tq_sel = '0, sclkout_cfg = '0;
   logic       half_en = 1'b0, mclk_idle = 1'b0, sclkout_sel = 1'b0;
   logic [9:0] pdiv = '0;
   logic [1:0] tq_pre = '0;
   logic [4:0] tq_den = '0;
   logic       mclk_o, sclkout_o, ppp_en_o, pdiv_en_o, tq_en_o;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ser_clkgen uut (
      .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .frac_en_i(frac_en_i),
      .trig_i(trig_i), .ext_clk_i(ext_clk_i), .src_sel(src_sel),
      .half_en(half_en), .pdiv(pdiv), .tq_sel(tq_sel), .tq_pre(tq_pre),
      .tq_den(tq_den), .sclkout_cfg(sclkout_cfg), .mclk_idle(mclk_idle),
      .sclkout_sel(sclkout_sel), .mclk_o(mclk_o), .sclkout_o(sclkout_o),
      .ppp_en_o(ppp_en_o), .pdiv_en_o(pdiv_en_o), .tq_en_o(tq_en_o)
   );

   // reference model state, built from the requirements
   logic t1, t2, t3, e1, e2, e3;          // synchronizers (R2, R3)
   logic hp;                               // halving phase (R4)
   int   pcnt, prc, dnc;                   // divider counts (R5, R8)
   logic sc, scd, sch, mch;                // shift clock, delayed, edge history

   function automatic logic f_pin(logic [1:0] s, logic fr, logic tr, logic er);
      if (s == 2'd2) return tr;
      if (s == 2'd3) return er;
      return fr;                           // codes 0 and 1 (R1)
   endfunction

   logic m_pin, m_ppp, m_pdiv, m_mraw, m_tqin, m_pre, m_tq, m_mclk, m_sclkout;
   always_comb begin
      m_pin  = gen_en & f_pin(src_sel, frac_en_i, t2 & ~t3, e2 & ~e3);
      m_ppp  = half_en ? (m_pin & hp) : m_pin;
      m_pdiv = m_ppp && (pcnt == int'(pdiv));
      m_mraw = (!half_en && src_sel == 2'd3) ? e2 : hp;
      case (tq_sel)
         2'd0: m_tqin = m_pdiv;
         2'd1: m_tqin = m_ppp;
         2'd2: m_tqin = sc & ~sch;
         default: m_tqin = m_mraw & ~mch;
      endcase
      m_tqin   = m_tqin & gen_en;
      m_pre    = m_tqin && (prc == int'(tq_pre));
      m_tq     = m_pre && (dnc == int'(tq_den));
      m_mclk   = gen_en ? (m_mraw ^ mclk_idle) : mclk_idle;
      m_sclkout = !gen_en ? sclkout_cfg[0]
                : sclkout_sel ? e2
                : ((sclkout_cfg[1] ? scd : sc) ^ sclkout_cfg[0]);
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {t1, t2, t3, e1, e2, e3} <= '0;
         hp <= 0; pcnt <= 0; prc <= 0; dnc <= 0;
         sc <= 0; scd <= 0; sch <= 0; mch <= 0;
      end else begin
         t1 <= trig_i; t2 <= t1; t3 <= t2;
         e1 <= ext_clk_i; e2 <= e1; e3 <= e2;
         if (!gen_en) begin
            hp <= 0; pcnt <= 0; prc <= 0; dnc <= 0;
            sc <= 0; scd <= 0; sch <= 0; mch <= 0;
         end else begin
            if (m_pin) hp <= ~hp;
            if (m_ppp) pcnt <= m_pdiv ? 0 : pcnt + 1;
            if (m_tqin) prc <= m_pre ? 0 : prc + 1;
            if (m_pre) dnc <= m_tq ? 0 : dnc + 1;
            if (m_pdiv) begin sc <= ~sc; scd <= sc; end
            sch <= sc;
            mch <= m_mraw;
         end
      end
   end

   task automatic check(string tag, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string mclk_tag();
      if (!gen_en) return "R12 mclk idle";
      if (half_en) return "R4 R10 mclk halved";
      if (src_sel == 2'd3) return "R3 R10 mclk follows ext";
      if (src_sel == 2'd2) return "R2 R10 mclk toggles on trigger";
      return "R1 R10 mclk";
   endfunction

   function automatic string sclk_tag();
      if (!gen_en) return "R12 sclkout idle";
      if (sclkout_sel) return "R11 sclkout external";
      if (sclkout_cfg[1]) return "R9 sclkout delayed";
      return "R6 R9 sclkout";
   endfunction

   task automatic check_all();
      check(mclk_tag(), mclk_o, m_mclk);
      check(sclk_tag(), sclkout_o, m_sclkout);
      check(half_en ? "R4 ppp halved" : "R1 R2 R3 R4 ppp rate", ppp_en_o, m_ppp);
      check("R5 divided pulse", pdiv_en_o, m_pdiv);
      check("R7 R8 time quantum", tq_en_o, m_tq);
   endtask

   task automatic drive_random();
      frac_en_i = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) trig_i = ~trig_i;
      if (($urandom % 3) == 0) ext_clk_i = ~ext_clk_i;
   endtask

   initial begin
      void'($urandom(32'h5eed_c10c));
      repeat (3) @(negedge clk);
      // reset state (R12)
      check("R12 reset mclk", mclk_o, 1'b0);
      check("R12 reset sclkout", sclkout_o, 1'b0);
      check("R12 reset pulses", ppp_en_o | pdiv_en_o | tq_en_o, 1'b0);
      rst_n = 1'b1;
      for (int ph = 0; ph < 28; ph++) begin
         @(negedge clk);
         gen_en = 1'b0;
         case (ph)
            0: begin src_sel = 2'd0; half_en = 0; pdiv = 10'd0; tq_sel = 2'd0;
                     tq_pre = 2'd0; tq_den = 5'd0; sclkout_cfg = 2'd0;
                     mclk_idle = 0; sclkout_sel = 0; end
            1: begin src_sel = 2'd2; half_en = 1; pdiv = 10'd1; tq_sel = 2'd1;
                     tq_pre = 2'd1; tq_den = 5'd2; sclkout_cfg = 2'd2;
                     mclk_idle = 1; sclkout_sel = 0; end
            2: begin src_sel = 2'd3; half_en = 0; pdiv = 10'd2; tq_sel = 2'd3;
                     tq_pre = 2'd0; tq_den = 5'd1; sclkout_cfg = 2'd3;
                     mclk_idle = 0; sclkout_sel = 0; end
            3: begin src_sel = 2'd1; half_en = 0; pdiv = 10'd0; tq_sel = 2'd2;
                     tq_pre = 2'd3; tq_den = 5'd31; sclkout_cfg = 2'd1;
                     mclk_idle = 1; sclkout_sel = 1; end
            default: begin
               src_sel = 2'($urandom); half_en = 1'($urandom);
               pdiv = 10'($urandom % 6); tq_sel = 2'($urandom);
               tq_pre = 2'($urandom); tq_den = 5'($urandom % 4);
               sclkout_cfg = 2'($urandom); mclk_idle = 1'($urandom);
               sclkout_sel = (($urandom % 4) == 0);
            end
         endcase
         for (int c = 0; c < 4; c++) begin   // disabled window (R12)
            drive_random();
            @(negedge clk);
            check_all();
         end
         gen_en = 1'b1;
         for (int c = 0; c < 400; c++) begin
            if (ph == 0) frac_en_i = 1'b1; else drive_random();
            @(negedge clk);
            check_all();
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule